// File: doc/BRIEF.md
# Buffered 16-bit Timer Peripheral

This block is a 16-bit up-counter reached through a byte-wide register bus. Software sees four byte registers: the counter's low byte, its high byte, a control byte and a status byte. The counter advances on internal tick pulses or on rising edges of an external input. A prescaler divides those events by 1, 2, 4 or 8. When the counter wraps from all ones to zero it raises a sticky flag, and the flag drives an interrupt line through an enable bit.

The counter is 16 bits wide but the bus moves one byte at a time. A buffered mode keeps two-step accesses coherent. In this mode a low-byte read also takes a snapshot of the live high byte into a shadow register. A low-byte write commits the shadow register into the live high byte in the same edge. A trigger input, which a compare unit elsewhere can drive, clears the counter so that the counter runs with a programmable period. All logic runs on one system clock, and the external input is edge-detected on that clock.

Top module: `tmr16_periph`

## Requirements
- R1: After reset all four registers read 0x00 and `irq` is low.
- R2: The register select is address 0 for the low count byte, 1 for the high byte, 2 for control and 3 for status. Read data appears on `bus_rdata` in the cycle after the read strobe. With buffered mode off, address 1 reads and writes the live high byte. With control bits 3:2 at 0, each internal tick advances the count by one.
- R3: Control bit 0 enables counting, and while it is clear the count holds. Control bits 3:2 hold a value n, and the counter advances once per 2^n qualifying events.
- R4: A write to address 0 restarts the prescaler phase. A write to address 1 leaves the prescaler phase unchanged.
- R5: Control bit 7 selects buffered mode. In buffered mode a read of address 1 returns the shadow byte, and a read of address 0 copies the live high byte into the shadow byte in that same access.
- R6: In buffered mode a write to address 1 changes only the shadow byte. A write to address 0 loads the counter with {shadow, written byte} in one edge.
- R7: When the count passes from 0xFFFF to 0x0000, status bit 0 (flag) is set and stays set. `irq` equals the flag ANDed with status bit 1 (enable).
- R8: A status write with bit 0 at 0 clears the flag, and a status write with bit 0 at 1 leaves the flag as it is. A wrap in the same cycle as a clear leaves the flag set.
- R9: With control bit 4 set, a high `evt_trig` clears the count to 0. This clear takes priority over an increment and never sets the flag. With control bit 4 clear, `evt_trig` has no effect.
- R10: A counter write (address 0, or address 1 with buffered mode off) in the same cycle as an enabled trigger takes effect, and the trigger is ignored.
- R11: Control bit 1 selects the external clock. In that mode the count advances only on 0-to-1 transitions of `ext_clk` as sampled on `clk`, and `tick_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored while `bus_wr` is high) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_in | input | 1 | Internal count pulse |
| ext_clk | input | 1 | External count input, already synchronous |
| evt_trig | input | 1 | Counter clear request from a compare unit |
| irq | output | 1 | Overflow interrupt |

## Verification
Four pairs of functions can land in the same cycle. A wrap can meet a flag-clearing status write. A trigger can meet an increment from the counter's all-ones value. A trigger can meet a low-byte write, and it can meet a direct high-byte write. The bench drives both stimuli on the same falling edge, so that one rising edge samples both. It then reads the counter and status back through the bus and compares them with the priority order in R8, R9 and R10. A rollover between the two halves of a buffered read is provoked in the same way, with a tick placed between the low-byte and high-byte reads.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    localparam int CB_RUN  = 0;
    localparam int CB_EXT  = 1;
    localparam int CB_PS   = 2;
    localparam int SB_FLAG = 0;
    localparam int SB_IE   = 1;

endpackage

// File: rtl/tmr16_clkgen.sv
module tmr16_clkgen #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ext_sel,
    input  logic [PS_W-1:0] ps,
    input  logic            tick_in,
    input  logic            ext_in,
    input  logic            pre_clr,
    output logic            inc
);
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic             ext_prev;
        logic [PRE_W-1:0] pre;
    } state_t;

    state_t state_d, state_q;
    logic [PRE_W:0]   div_n;
    logic [PRE_W-1:0] lim;
    logic             evt;

    always_comb begin
        state_d          = state_q;
        state_d.ext_prev = ext_in;
        div_n            = (PRE_W+1)'(1) << ps;
        lim              = PRE_W'(div_n - (PRE_W+1)'(1));
        evt              = run & (ext_sel ? (ext_in & ~state_q.ext_prev) : tick_in);
        inc              = 1'b0;
        if (pre_clr) begin
            state_d.pre = '0;
        end else if (evt) begin
            if (state_q.pre >= lim) begin
                inc         = 1'b1;
                state_d.pre = '0;
            end else begin
                state_d.pre = state_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // A tick at division 1 must count at once
    assert_div1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext_sel && ps == '0 && tick_in && !pre_clr) |-> inc);

    // A counting event without run never advances the phase
    assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pre_clr) |=> $stable(state_q.pre));

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                buf_mode,
    input  logic                trig,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                rd_lo,
    input  logic                flag_clr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [BYTE_W-1:0]   shadow,
    output logic                flag
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shadow;
        logic              flag;
    } state_t;

    state_t state_d, state_q;
    logic hi_live, hi_shadow, wrap;

    always_comb begin
        state_d   = state_q;
        hi_live   = wr_hi & ~buf_mode;
        hi_shadow = wr_hi & buf_mode;
        wrap      = 1'b0;
        if (wr_lo) begin
            state_d.cnt[BYTE_W-1:0] = wdata;
            if (buf_mode) state_d.cnt[CNT_W-1:BYTE_W] = state_q.shadow;
        end else if (hi_live) begin
            state_d.cnt[CNT_W-1:BYTE_W] = wdata;
        end else if (trig) begin
            state_d.cnt = '0;
        end else if (inc) begin
            state_d.cnt = state_q.cnt + 1'b1;
            wrap        = (state_q.cnt == '1);
        end
        if (hi_shadow)
            state_d.shadow = wdata;
        else if (rd_lo && buf_mode)
            state_d.shadow = state_q.cnt[CNT_W-1:BYTE_W];
        if (wrap)
            state_d.flag = 1'b1;
        else if (flag_clr)
            state_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt    = state_q.cnt;
    assign shadow = state_q.shadow;
    assign flag   = state_q.flag;

    assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && buf_mode && !wr_hi) |=> shadow == $past(cnt[CNT_W-1:BYTE_W]));

    assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && buf_mode) |=> cnt == {$past(shadow), $past(wdata)});

    assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == '1 && $past(inc)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(inc && cnt == '1)) |=> !flag);

    assert_trig_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !wr_lo && !(wr_hi && !buf_mode)) |=> (cnt == '0 && !$rose(flag)));

endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph #(
    parameter int BYTE_W = 8,
    parameter int PS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_in,
    input  logic              ext_clk,
    input  logic              evt_trig,
    output logic              irq
);
    import tmr16_pkg::*;

    localparam int CNT_W   = 2 * BYTE_W;
    localparam int CB_TRIG = CB_PS + PS_W;
    localparam int CB_BUF  = BYTE_W - 1;

    typedef struct packed {
        logic              run;
        logic              ext_sel;
        logic [PS_W-1:0]   ps;
        logic              trig_en;
        logic              buf_mode;
        logic              ie;
        logic [BYTE_W-1:0] rdata;
    } state_t;

    state_t            state_d, state_q;
    reg_sel_e          sel;
    logic              wr_lo, wr_hi, wr_ctrl, wr_stat, rd_lo, rd_any;
    logic              inc, flag, trig_eff;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shadow, rd_val;

    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        wr_lo    = bus_wr && sel == REG_CNT_LO;
        wr_hi    = bus_wr && sel == REG_CNT_HI;
        wr_ctrl  = bus_wr && sel == REG_CTRL;
        wr_stat  = bus_wr && sel == REG_STAT;
        rd_any   = bus_rd && !bus_wr;
        rd_lo    = rd_any && sel == REG_CNT_LO;
        trig_eff = evt_trig && state_q.trig_en;

        rd_val = '0;
        unique case (sel)
            REG_CNT_LO: rd_val = cnt[BYTE_W-1:0];
            REG_CNT_HI: rd_val = state_q.buf_mode ? shadow : cnt[CNT_W-1:BYTE_W];
            REG_CTRL: begin
                rd_val[CB_RUN]           = state_q.run;
                rd_val[CB_EXT]           = state_q.ext_sel;
                rd_val[CB_PS +: PS_W]    = state_q.ps;
                rd_val[CB_TRIG]          = state_q.trig_en;
                rd_val[CB_BUF]           = state_q.buf_mode;
            end
            REG_STAT: begin
                rd_val[SB_FLAG] = flag;
                rd_val[SB_IE]   = state_q.ie;
            end
            default: rd_val = '0;
        endcase

        state_d = state_q;
        if (rd_any) state_d.rdata = rd_val;
        if (wr_ctrl) begin
            state_d.run      = bus_wdata[CB_RUN];
            state_d.ext_sel  = bus_wdata[CB_EXT];
            state_d.ps       = bus_wdata[CB_PS +: PS_W];
            state_d.trig_en  = bus_wdata[CB_TRIG];
            state_d.buf_mode = bus_wdata[CB_BUF];
        end
        if (wr_stat) state_d.ie = bus_wdata[SB_IE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    tmr16_clkgen #(.PS_W(PS_W)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q.run),
        .ext_sel (state_q.ext_sel),
        .ps      (state_q.ps),
        .tick_in (tick_in),
        .ext_in  (ext_clk),
        .pre_clr (wr_lo),
        .inc     (inc)
    );

    tmr16_core #(.BYTE_W(BYTE_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .buf_mode (state_q.buf_mode),
        .trig     (trig_eff),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_lo    (rd_lo),
        .flag_clr (wr_stat && !bus_wdata[SB_FLAG]),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .shadow   (shadow),
        .flag     (flag)
    );

    assign bus_rdata = state_q.rdata;
    assign irq       = flag & state_q.ie;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.run && !wr_lo && !wr_hi && !trig_eff) |=> $stable(cnt));

    assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && trig_eff) |=> cnt[BYTE_W-1:0] == $past(bus_wdata));

    assert_ext_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ext_sel && !ext_clk && !wr_lo && !wr_hi && !trig_eff) |=> $stable(cnt));

endmodule

// File: tb/test_tmr16_periph.sv
`timescale 1ns/1ps
module test_tmr16_periph;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0, ext_clk = 1'b0, evt_trig = 1'b0;
    logic       irq;

    typedef struct { string tag; logic [7:0] exp; } item_t;
    item_t exp_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    logic  rd_d = 1'b0;

    always #4 clk = ~clk;

    tmr16_periph i_tmr16_periph (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .ext_clk(ext_clk), .evt_trig(evt_trig), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(posedge clk) rd_d <= bus_rd && !bus_wr;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 8'h00, 8'h01);
            else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        it.tag = tag; it.exp = e; exp_q.push_back(it);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            @(negedge clk); @(negedge clk); ext_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_count(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 8'h00, "R1 low"); rd(2'd1, 8'h00, "R1 high");
        rd(2'd2, 8'h00, "R1 ctrl"); rd(2'd3, 8'h00, "R1 stat");
        @(negedge clk); check("R1 irq", {7'd0, irq}, 8'h00);

        // R2 basic counting, direct high byte
        wr(2'd2, 8'h01); tick(5);
        rd(2'd0, 8'h05, "R2 count"); rd(2'd1, 8'h00, "R2 high");
        wr(2'd1, 8'h12);
        rd(2'd1, 8'h12, "R2 live high"); rd(2'd0, 8'h05, "R2 low kept");
        rd(2'd2, 8'h01, "R2 ctrl readback");

        // R3 prescaler
        wr(2'd2, 8'h09); set_count(16'h0000); tick(8);
        rd(2'd0, 8'h02, "R3 div4");
        wr(2'd2, 8'h0D); set_count(16'h0000); tick(7);
        rd(2'd0, 8'h00, "R3 div8 pre"); tick(1);
        rd(2'd0, 8'h01, "R3 div8");

        // R4 prescaler clear rules
        wr(2'd2, 8'h05); set_count(16'h0000); tick(1);
        wr(2'd1, 8'h00); tick(1);
        rd(2'd0, 8'h01, "R4 high write keeps phase");
        tick(1); wr(2'd0, 8'h10); tick(1);
        rd(2'd0, 8'h10, "R4 low write clears phase");

        // R3 run bit off holds
        wr(2'd2, 8'h00); tick(3);
        rd(2'd0, 8'h10, "R3 hold");

        // R5 / R6 buffered mode
        wr(2'd2, 8'h01); set_count(16'h00FE);
        wr(2'd2, 8'h81); wr(2'd1, 8'h34);
        rd(2'd1, 8'h34, "R6 shadow write"); tick(1);
        rd(2'd0, 8'hFF, "R5 low"); rd(2'd1, 8'h00, "R5 snapshot");
        rd(2'd0, 8'hFF, "R5 low before roll"); tick(1);
        rd(2'd1, 8'h00, "R5 coherent across rollover");
        rd(2'd0, 8'h00, "R5 low after roll"); rd(2'd1, 8'h01, "R5 new snapshot");
        wr(2'd1, 8'h56); wr(2'd0, 8'h78);
        rd(2'd0, 8'h78, "R6 commit low"); rd(2'd1, 8'h56, "R6 commit high");
        wr(2'd1, 8'h99); wr(2'd2, 8'h01);
        rd(2'd1, 8'h56, "R6 live untouched");

        // R7 overflow flag and irq
        set_count(16'hFFFE); tick(1);
        rd(2'd3, 8'h00, "R7 no flag yet"); tick(1);
        rd(2'd3, 8'h01, "R7 flag"); rd(2'd0, 8'h00, "R7 wrap low"); rd(2'd1, 8'h00, "R7 wrap high");
        @(negedge clk); check("R7 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h03);
        @(negedge clk); check("R7 irq", {7'd0, irq}, 8'h01);
        rd(2'd3, 8'h03, "R8 write one keeps");
        wr(2'd3, 8'h02);
        @(negedge clk); check("R8 irq cleared", {7'd0, irq}, 8'h00);
        rd(2'd3, 8'h02, "R8 clear");

        // R8 wrap beats clear
        set_count(16'hFFFF);
        @(negedge clk); bus_addr = 2'd3; bus_wdata = 8'h02; bus_wr = 1'b1; tick_in = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tick_in = 1'b0;
        rd(2'd3, 8'h03, "R8 set wins"); rd(2'd0, 8'h00, "R8 wrapped");
        wr(2'd3, 8'h02);

        // R9 trigger
        wr(2'd2, 8'h11); set_count(16'h1234);
        @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd(2'd0, 8'h00, "R9 trig low"); rd(2'd1, 8'h00, "R9 trig high");
        wr(2'd2, 8'h01); set_count(16'h1234);
        @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd(2'd0, 8'h34, "R9 disabled trig");
        wr(2'd2, 8'h11); set_count(16'hFFFF);
        @(negedge clk); evt_trig = 1'b1; tick_in = 1'b1;
        @(negedge clk); evt_trig = 1'b0; tick_in = 1'b0;
        rd(2'd0, 8'h00, "R9 trig over inc"); rd(2'd3, 8'h02, "R9 no flag");
        @(negedge clk); check("R9 irq", {7'd0, irq}, 8'h00);

        // R10 write beats trigger
        set_count(16'h1200);
        @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h44; bus_wr = 1'b1; evt_trig = 1'b1;
        @(negedge clk); bus_wr = 1'b0; evt_trig = 1'b0;
        rd(2'd0, 8'h44, "R10 low write"); rd(2'd1, 8'h12, "R10 high kept");
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h77; bus_wr = 1'b1; evt_trig = 1'b1;
        @(negedge clk); bus_wr = 1'b0; evt_trig = 1'b0;
        rd(2'd1, 8'h77, "R10 high write"); rd(2'd0, 8'h44, "R10 low kept");

        // R11 external clock
        wr(2'd2, 8'h03); set_count(16'h0000);
        ext_pulse(1); tick(2);
        rd(2'd0, 8'h01, "R11 one edge, ticks ignored");
        ext_pulse(4);
        rd(2'd0, 8'h05, "R11 edges");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule